// File: doc/BRIEF.md
# Seven-Level Phase-Disposition PWM Gate Controller

This block produces the ten gate enables of a single-phase seven-level inverter. The power stage has two parts. A fast level stage of six switches only ever builds a non-negative voltage step, from 0 to 3. A four-switch full bridge then passes that step to the load either forward or reversed. The controller takes one signed reference sample per clock. It splits the sample into a magnitude and a sign. The magnitude is compared against three stacked triangular carriers, which are all in phase and share one counter. The result of that comparison selects the level step. The sign alone steers the bridge.

Each gate passes through a dead-time stage before it reaches the pins. A gate that is about to turn on waits a programmable number of cycles after every gate it conflicts with has turned off. When the reference changes sign, the level stage is parked on its zero pattern while the bridge is switched off and then switched onto the other diagonal. Because of this, bridge switching happens only at zero crossings. The carrier peak and the dead-time length are configuration inputs. They are meant to be changed only while reset is held.

Top module: `ml_pwm_ctrl`

## Requirements
- R1: While `rst` is high, all six level-stage gates and all four bridge gates are driven low.
- R2: The magnitude is |ref_i| for a two's-complement `ref_i`. The most negative input saturates to 2^(CW+2)-1. The band is magnitude bits [CW+1:CW] and the residual is bits [CW-1:0]. Band 3 always selects level 3.
- R3: A single carrier count runs as a triangle 0,1,…,peak,peak-1,…,1 and repeats every 2·peak cycles. The carrier for band k is k·2^CW plus this count, so the three carriers are in phase and do not overlap.
- R4: In band b (b = 0, 1 or 2), level b+1 is chosen when the residual is at or above the carrier count. Otherwise level b is chosen. With peak 0 this means band b always gives level b+1.
- R5: Bit i of `fast_o` drives fast switch i+1. The level patterns are: level 0 = 6'b001110, level 1 = 6'b010110, level 2 = 6'b110010, level 3 = 6'b010001.
- R6: A reference at or above zero selects the forward diagonal, `bridge_o` = 4'b0110. A negative reference selects the reverse diagonal, 4'b1001. The bridge moves from one diagonal to the other exactly once for each sign change of the reference, and never on a change of magnitude alone.
- R7: The conflicting gates are `fast_o` bits 0/1, 2/5 and 3/4, and bridge bits {1,2} against bits {0,3}. A gate turns on only after every gate it conflicts with has been off for at least `dead_i`+1 consecutive cycles.
- R8: While a polarity change is under way, the level stage is forced to level 0. A level-stage gate outside the level-0 pattern (`fast_o` bits 0, 4, 5) rises only if the bridge showed a complete diagonal in the cycle before.
- R9: At every cycle, `fast_o` is a subset of one level pattern and `bridge_o` is a subset of one diagonal.
- R10: Hold the reference at constant sign with band b < 3 and residual r, where peak > r. Then in each carrier period the full higher pattern is present for 2r-dead cycles and the full lower pattern for 2·peak-2r-dead-2 cycles. This holds as long as both runs last longer than dead+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | CW+3 | Signed reference sample |
| peak_i | input | CW | Carrier peak count |
| dead_i | input | DTW | Dead-time length in cycles |
| fast_o | output | 6 | Level-stage gate enables, bit i = switch i+1 |
| bridge_o | output | 4 | Polarity-bridge gate enables |

## Verification
The dead-time and pattern-subset properties assume that `peak_i` and `dead_i` stay fixed outside reset. A change of either one during operation could shorten an off interval that a property measures. The stimulus therefore sets a fresh configuration only inside a reset pulse. It holds each reference value long enough for the triangular carrier to reach a steady period before any duty counts are taken. Random trials pick the residual far enough from both band edges that each pulse outlasts the dead time, which is the condition the duty formula relies on.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  localparam int NFAST = 6;
  localparam int NBRG  = 4;
  localparam int NPAIR = 3;

  typedef logic [NFAST-1:0] fast_t;
  typedef logic [NBRG-1:0]  brg_t;

  localparam fast_t PAT_L0 = 6'b001110;
  localparam fast_t PAT_L1 = 6'b010110;
  localparam fast_t PAT_L2 = 6'b110010;
  localparam fast_t PAT_L3 = 6'b010001;

  localparam brg_t DIAG_FWD = 4'b0110;
  localparam brg_t DIAG_REV = 4'b1001;

  function automatic fast_t level_pattern(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return PAT_L0;
      2'd1:    return PAT_L1;
      2'd2:    return PAT_L2;
      default: return PAT_L3;
    endcase
  endfunction

  // complementary fast-switch pairs: low and high bit index of each
  function automatic int pair_lo(input int g);
    case (g)
      0:       return 0;
      1:       return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int pair_hi(input int g);
    case (g)
      0:       return 1;
      1:       return 5;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] peak_i,
  output logic [CW-1:0] cnt_o
);
  logic          up_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= peak_i) begin
        up_q <= 1'b0;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        up_q <= 1'b1;
        if (peak_i != '0) cnt_q <= {{(CW-1){1'b0}}, 1'b1};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mlpwm_level_sel.sv
module mlpwm_level_sel #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW+2:0] ref_i,
  input  logic [CW-1:0] cnt_i,
  output logic [1:0]    lvl_o,
  output logic          neg_o
);
  localparam int MW    = CW + 2;
  localparam int RW    = CW + 3;
  localparam int NBAND = 3;

  logic [RW-1:0]    absval;
  logic [MW-1:0]    mag_d, mag_q;
  logic             neg1_q, neg2_q;
  logic [NBAND-1:0] above;
  logic [1:0]       lvl_q;

  always_comb begin
    absval = ref_i[RW-1] ? (~ref_i + 1'b1) : ref_i;
    mag_d  = absval[RW-1] ? {MW{1'b1}} : absval[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      neg1_q <= 1'b0;
    end else begin
      mag_q  <= mag_d;
      neg1_q <= ref_i[RW-1];
    end
  end

  // stacked in-phase carriers: band k sits at k*2^CW plus the shared count
  for (genvar k = 0; k < NBAND; k++) begin : g_band
    logic [MW-1:0] carrier;
    assign carrier  = {2'(k), cnt_i};
    assign above[k] = (mag_q >= carrier);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 2'd0;
      neg2_q <= 1'b0;
    end else begin
      lvl_q  <= 2'($countones(above));
      neg2_q <= neg1_q;
    end
  end

  assign lvl_o = lvl_q;
  assign neg_o = neg2_q;
endmodule

// File: rtl/mlpwm_polarity.sv
module mlpwm_polarity
  import mlpwm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic neg_i,
  input  brg_t brg_gate_i,
  output brg_t brg_want_o,
  output logic park_o
);
  logic pol_q;

  always_ff @(posedge clk) begin
    if (rst) pol_q <= 1'b0;
    else     pol_q <= neg_i;
  end

  assign brg_want_o = pol_q ? DIAG_REV : DIAG_FWD;
  // park the level stage from the first sign difference until the new diagonal is fully on
  assign park_o = (neg_i != pol_q) || (brg_gate_i != brg_want_o);
endmodule

// File: rtl/mlpwm_deadband.sv
module mlpwm_deadband #(
  parameter int N   = 2,
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DTW-1:0] dead_i,
  input  logic [N-1:0]   want_i,
  output logic [N-1:0]   gate_o
);
  logic [N-1:0]   gate_q;
  logic [DTW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      idle_q <= '0;
    end else if (|(gate_q & ~want_i)) begin
      gate_q <= gate_q & want_i;
      idle_q <= '0;
    end else begin
      if (idle_q >= dead_i) gate_q <= want_i;
      if (idle_q != {DTW{1'b1}}) idle_q <= idle_q + 1'b1;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/ml_pwm_ctrl.sv
module ml_pwm_ctrl
  import mlpwm_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW+2:0] ref_i,
  input  logic [CW-1:0] peak_i,
  input  logic [DTW-1:0] dead_i,
  output logic [5:0]    fast_o,
  output logic [3:0]    bridge_o
);
  logic [CW-1:0] cnt;
  logic [1:0]    lvl;
  logic          neg;
  logic          park;
  brg_t          brg_want;
  brg_t          brg_gate;
  fast_t         fast_want;
  fast_t         fast_gate;

  mlpwm_carrier #(.CW(CW)) u_carrier (
    .clk    (clk),
    .rst    (rst),
    .peak_i (peak_i),
    .cnt_o  (cnt)
  );

  mlpwm_level_sel #(.CW(CW)) u_level (
    .clk   (clk),
    .rst   (rst),
    .ref_i (ref_i),
    .cnt_i (cnt),
    .lvl_o (lvl),
    .neg_o (neg)
  );

  mlpwm_polarity u_pol (
    .clk        (clk),
    .rst        (rst),
    .neg_i      (neg),
    .brg_gate_i (brg_gate),
    .brg_want_o (brg_want),
    .park_o     (park)
  );

  assign fast_want = park ? PAT_L0 : level_pattern(lvl);

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam int LO = pair_lo(g);
    localparam int HI = pair_hi(g);
    logic [1:0] pw, pg;
    assign pw = {fast_want[HI], fast_want[LO]};
    mlpwm_deadband #(.N(2), .DTW(DTW)) u_db (
      .clk    (clk),
      .rst    (rst),
      .dead_i (dead_i),
      .want_i (pw),
      .gate_o (pg)
    );
    assign fast_gate[LO] = pg[0];
    assign fast_gate[HI] = pg[1];
  end

  mlpwm_deadband #(.N(NBRG), .DTW(DTW)) u_brg_db (
    .clk    (clk),
    .rst    (rst),
    .dead_i (dead_i),
    .want_i (brg_want),
    .gate_o (brg_gate)
  );

  assign fast_o   = fast_gate;
  assign bridge_o = brg_gate;
endmodule

// File: rtl/ml_pwm_ctrl_chk.sv
module ml_pwm_ctrl_chk
  import mlpwm_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [DTW-1:0] dead_i,
  input logic [5:0]    fast_o,
  input logic [3:0]    bridge_o
);
  localparam int NG = NFAST + NBRG;

  logic [NG-1:0] gates;
  logic [DTW:0]  off_cnt [NG];
  logic [NG-1:0] clear_ok;

  assign gates = {bridge_o, fast_o};

  function automatic logic [NG-1:0] rivals(input int i);
    case (i)
      0: return 10'b0000000010;
      1: return 10'b0000000001;
      2: return 10'b0000100000;
      5: return 10'b0000000100;
      3: return 10'b0000010000;
      4: return 10'b0000001000;
      6, 9: return 10'b0110000000;
      default: return 10'b1001000000;
    endcase
  endfunction

  for (genvar i = 0; i < NG; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                   off_cnt[i] <= '1;
      else if (gates[i])         off_cnt[i] <= '0;
      else if (off_cnt[i] != '1) off_cnt[i] <= off_cnt[i] + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NG; i++) begin
      clear_ok[i] = 1'b1;
      for (int j = 0; j < NG; j++)
        if (rivals(i)[j] && (off_cnt[j] <= {1'b0, dead_i})) clear_ok[i] = 1'b0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (fast_o == '0 && bridge_o == '0)); // R1

  AST_FAST_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ((fast_o & ~PAT_L0) == '0) || ((fast_o & ~PAT_L1) == '0) ||
    ((fast_o & ~PAT_L2) == '0) || ((fast_o & ~PAT_L3) == '0)); // R9

  AST_BRIDGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ((bridge_o & ~DIAG_FWD) == '0) || ((bridge_o & ~DIAG_REV) == '0)); // R9

  AST_PARK_DURING_SWAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(fast_o[0]) || $rose(fast_o[4]) || $rose(fast_o[5])) |->
      $past(bridge_o == DIAG_FWD || bridge_o == DIAG_REV)); // R8

  for (genvar i = 0; i < NG; i++) begin : g_dt
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
      $rose(gates[i]) |-> clear_ok[i]); // R7
  end
endmodule

bind ml_pwm_ctrl ml_pwm_ctrl_chk #(.CW(CW), .DTW(DTW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dead_i   (dead_i),
  .fast_o   (fast_o),
  .bridge_o (bridge_o)
);

// File: tb/ml_pwm_ctrl_test.sv
`timescale 1ns/1ps
module ml_pwm_ctrl_test;
  localparam int CW  = 8;
  localparam int DTW = 4;
  localparam int RW  = CW + 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [RW-1:0]  ref_i = '0;
  logic [CW-1:0]  peak_i = '0;
  logic [DTW-1:0] dead_i = 4'd2;
  logic [5:0]     fast_o;
  logic [3:0]     bridge_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ml_pwm_ctrl #(.CW(CW), .DTW(DTW)) uut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .peak_i(peak_i), .dead_i(dead_i),
    .fast_o(fast_o), .bridge_o(bridge_o)
  );

  // expected values from the requirements
  function automatic logic [5:0] exp_pat(input int lvl);
    case (lvl)
      0: return 6'b001110;
      1: return 6'b010110;
      2: return 6'b110010;
      default: return 6'b010001;
    endcase
  endfunction

  function automatic logic [3:0] exp_diag(input bit negative);
    return negative ? 4'b1001 : 4'b0110;
  endfunction

  function automatic bit rival(input int i, input int j);
    if ((i==0 && j==1) || (i==1 && j==0)) return 1;
    if ((i==2 && j==5) || (i==5 && j==2)) return 1;
    if ((i==3 && j==4) || (i==4 && j==3)) return 1;
    if ((i==7 || i==8) && (j==6 || j==9)) return 1;
    if ((i==6 || i==9) && (j==7 || j==8)) return 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // continuous monitors
  logic [9:0] prev_g = '0;
  int offcnt [10];
  initial for (int k = 0; k < 10; k++) offcnt[k] = 0;

  always @(negedge clk) begin
    logic [9:0] cur;
    cur = {bridge_o, fast_o};
    if (!rst) begin
      // R9 fast pattern subset of one level pattern
      check(((fast_o & ~exp_pat(0)) == 0) || ((fast_o & ~exp_pat(1)) == 0) ||
            ((fast_o & ~exp_pat(2)) == 0) || ((fast_o & ~exp_pat(3)) == 0),
            "R9", "fast subset", fast_o, 0);
      check(((bridge_o & ~exp_diag(0)) == 0) || ((bridge_o & ~exp_diag(1)) == 0),
            "R9", "bridge subset", bridge_o, 0);
      for (int i = 0; i < 10; i++) begin
        if (cur[i] && !prev_g[i]) begin
          for (int j = 0; j < 10; j++)
            if (rival(i, j))
              check(offcnt[j] >= int'(dead_i) + 1, "R7", "rival off time", offcnt[j],
                    int'(dead_i) + 1);
          if (i == 0 || i == 4 || i == 5)
            check(prev_g[9:6] == 4'b0110 || prev_g[9:6] == 4'b1001, "R8",
                  "bridge before non-zero rise", prev_g[9:6], 6);
        end
      end
    end
    for (int k = 0; k < 10; k++) offcnt[k] = cur[k] ? 0 : offcnt[k] + 1;
    prev_g = cur;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_reset(input int peak, input int dead);
    @(negedge clk);
    rst = 1'b1;
    peak_i = CW'(peak);
    dead_i = DTW'(dead);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(fast_o == 0 && bridge_o == 0, "R1", "gates in reset",
            {bridge_o, fast_o}, 0);
    end
    rst = 1'b0;
  endtask

  task automatic set_ref(input int v);
    ref_i = RW'(v);
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic static_case(input int v, input int lvl, input bit negative, input string req);
    @(negedge clk);
    set_ref(v);
    wait_cyc(60);
    check(fast_o == exp_pat(lvl), req, "static fast", fast_o, exp_pat(lvl));
    check(bridge_o == exp_diag(negative), "R6", "static bridge", bridge_o,
          exp_diag(negative));
  endtask

  task automatic duty_case(input int peak, input int dead, input int band,
                           input int r, input bit negative);
    int mag, hi, lo, win, ehi, elo;
    do_reset(peak, dead);
    mag = band * (1 << CW) + r;
    set_ref(negative ? -mag : mag);
    wait_cyc(8 * peak + 4 * dead + 40);
    win = 4 * 2 * peak;
    hi = 0;
    lo = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (fast_o == exp_pat(band + 1)) hi++;
      if (fast_o == exp_pat(band)) lo++;
    end
    ehi = 4 * (2 * r - dead);
    elo = 4 * (2 * peak - 2 * r - dead - 2);
    check(hi == ehi, "R10", "higher level cycles (R3 R4)", hi, ehi);
    check(lo == elo, "R10", "lower level cycles (R3 R4)", lo, elo);
    check(bridge_o == exp_diag(negative), "R6", "bridge in duty run", bridge_o,
          exp_diag(negative));
  endtask

  initial begin
    int refs [9];
    int swaps, flips;
    logic [3:0] last_diag;
    void'($urandom(32'd20240611));

    // R1 plus R2/R4/R5 with a carrier pinned at zero
    do_reset(0, 2);
    static_case(0,     1, 1'b0, "R4");   // zero counts as positive
    static_case(255,   1, 1'b0, "R4");   // top of band 0
    static_case(256,   2, 1'b0, "R5");   // bottom of band 1
    static_case(300,   2, 1'b0, "R5");
    static_case(-1,    1, 1'b1, "R2");
    static_case(-600,  3, 1'b1, "R2");
    static_case(767,   3, 1'b0, "R5");
    static_case(-1024, 3, 1'b1, "R2");   // saturated magnitude

    // band 3 and band-2 top stay at level 3 with a large carrier
    do_reset(200, 1);
    foreach (refs[i]) refs[i] = 0;
    set_ref(768);
    wait_cyc(900);
    begin
      int n3 = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (fast_o == exp_pat(3)) n3++;
      end
      check(n3 == 400, "R2", "band 3 holds level 3", n3, 400);
      set_ref(767);
      wait_cyc(20);
      n3 = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (fast_o == exp_pat(3)) n3++;
      end
      check(n3 == 400, "R4", "residual max beats carrier", n3, 400);
    end

    // directed duty cases
    duty_case(20, 3, 0, 8, 1'b0);
    duty_case(24, 0, 1, 5, 1'b1);
    duty_case(16, 2, 2, 11, 1'b0);

    // constrained random duty cases
    for (int t = 0; t < 8; t++) begin
      int p, d, r, b;
      bit n;
      p = 12 + int'($urandom % 29);
      d = int'($urandom % 4);
      r = d + 2 + int'($urandom % (p - 2 * d - 4));
      b = int'($urandom % 3);
      n = 1'($urandom % 2);
      duty_case(p, d, b, r, n);
    end

    // polarity changes: R6 and R8 under sign flips
    do_reset(30, 4);
    refs = '{100, -100, -400, 400, 50, -700, 700, 10, -10};
    flips = 5;
    set_ref(refs[0]);
    wait_cyc(250);
    last_diag = 4'b0110;
    check(bridge_o == 4'b0110, "R6", "initial forward", bridge_o, 6);
    swaps = 0;
    for (int s = 1; s < 9; s++) begin
      set_ref(refs[s]);
      for (int k = 0; k < 250; k++) begin
        @(negedge clk);
        if ((bridge_o == 4'b0110 || bridge_o == 4'b1001) && bridge_o != last_diag) begin
          swaps++;
          last_diag = bridge_o;
        end
      end
    end
    check(swaps == flips, "R6", "one bridge swap per sign change", swaps, flips);
    check(bridge_o == 4'b1001, "R6", "final reverse", bridge_o, 9);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule